// File: doc/BRIEF.md
# Sub-Word Store Merge Unit

This block sits on the write path between a CPU core and a memory that is organised as 32-bit words. The core hands it store requests of byte, halfword or word size together with a byte address and the store data. The block places the low bits of the store data into the correct byte lanes, using a big-endian lane order, and drives one word-wide memory port.

A build-time parameter selects how sub-word stores reach memory. With lane strobes enabled, every store becomes a single write whose byte enables mark the lanes that change. With lane strobes disabled, the memory is assumed to accept only full words. A byte or halfword store then reads the containing word, replaces the addressed lanes and writes the whole word back. That sequence costs exactly three cycles more than the strobe path. Full-word stores never read in either build.

Toward the core the block has a valid/ready handshake. It accepts one store at a time and keeps ready low until that store's write has been issued.

Top module: `store_merge_unit`

## Requirements
- R1: While reset is asserted, ready, write and read are all low. Once reset has been released for three clock cycles, ready is high and both memory strobes are low.
- R2: With lane strobes enabled, an accepted store drives write high for exactly one cycle, in the cycle after acceptance, and read is never driven.
- R3: Size code 0 is a byte store. Address offset k (bits 1:0) enables only byte-enable bit 3-k. Store data bits 7:0 appear on write-data bits [31-8k:24-8k], and all other lanes are zero.
- R4: Size code 1 is a halfword store, and address bit 0 is ignored. Address bit 1 = 0 gives byte enables 1100 with data bits 15:0 on bits 31:16. Address bit 1 = 1 gives enables 0011 with data bits 15:0 on bits 15:0. Unused lanes are zero.
- R5: The memory word address is the request address shifted right by two, for every size and every phase. It is held stable from the read to the write-back.
- R6: With lane strobes disabled, a byte or halfword store drives read high for one cycle, in the cycle after acceptance. Write follows three cycles after the read, which is four cycles after acceptance and three cycles later than the strobe path. Read and write are never high together.
- R7: In the read-update-write sequence, the written word equals the word returned by memory, with only the addressed lanes replaced as in R3 and R4. All four byte enables are set.
- R8: With lane strobes disabled, a word store writes directly in the cycle after acceptance, with all enables set, and issues no read.
- R9: Ready is low from the cycle after acceptance until the cycle after the write. It is high again one cycle after the write.
- R10: Size codes 2 and 3 are both word stores. Address bits 1:0 are ignored, all byte enables are set, and the store data passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid_i | input | 1 | Store request present |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr_i | input | ADDR_W | Byte address of the store |
| req_wdata_i | input | 32 | Store data, right-aligned |
| req_ready_o | output | 1 | Block can accept a store this cycle |
| mem_addr_o | output | ADDR_W-2 | Word address toward memory |
| mem_re_o | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_we_o | output | 1 | Memory write strobe |
| mem_be_o | output | 4 | Byte enables, bit 3 is bits 31:24 |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after mem_re_o |

## Verification
A store is accepted at the clock edge where valid and ready are both high, and every result is counted from that edge.

- In the strobe build, the write with its enables and lane data is visible in the first cycle after acceptance, and ready returns in the second.
- In the read-update-write build, the read appears in the first cycle after acceptance. The merged write appears in the fourth, because the memory data arrives in the second cycle and the merge is registered in the third. Ready returns in the fifth.
- A full-word store in the read-update-write build writes in the first cycle.

The bench drives inputs on falling edges and samples at each following falling edge. It checks every port in each of these cycles, so a result that arrives one cycle early or late is reported.

// File: rtl/smu_pkg.sv
package smu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } st_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_MERGE = 3'd3,
    ST_WRITE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/smu_lane_map.sv
module smu_lane_map
  import smu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  st_size_e                       size_i,
  input  logic [$clog2(DATA_W/LANE_W)-1:0] off_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W/LANE_W-1:0]       strobe_o,
  output logic [DATA_W-1:0]              lanes_o
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int OFF_W = $clog2(NLANE);

  // lane index i counts from the most significant lane (big-endian)
  always_comb begin
    strobe_o = '0;
    lanes_o  = '0;
    for (int i = 0; i < NLANE; i++) begin
      unique case (size_i)
        SZ_BYTE: begin
          if (off_i == OFF_W'(i)) begin
            strobe_o[NLANE-1-i] = 1'b1;
            lanes_o[(NLANE-1-i)*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
          end
        end
        SZ_HALF: begin
          if (off_i[OFF_W-1] == (i >= NLANE/2)) begin
            strobe_o[NLANE-1-i] = 1'b1;
            lanes_o[(NLANE-1-i)*LANE_W +: LANE_W] =
              (i % 2 == 0) ? wdata_i[2*LANE_W-1:LANE_W] : wdata_i[LANE_W-1:0];
          end
        end
        default: begin
          strobe_o[NLANE-1-i] = 1'b1;
          lanes_o[(NLANE-1-i)*LANE_W +: LANE_W] = wdata_i[(NLANE-1-i)*LANE_W +: LANE_W];
        end
      endcase
    end
  end

endmodule

// File: rtl/smu_merge.sv
module smu_merge #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W/LANE_W-1:0] strobe_i,
  input  logic [DATA_W-1:0]        new_i,
  input  logic [DATA_W-1:0]        old_i,
  output logic [DATA_W-1:0]        word_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign word_o[g*LANE_W +: LANE_W] =
      strobe_i[g] ? new_i[g*LANE_W +: LANE_W] : old_i[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/smu_seq.sv
module smu_seq
  import smu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic go_long_i,
  output logic idle_o,
  output logic accept_o,
  output logic read_o,
  output logic capture_o,
  output logic merge_o,
  output logic write_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (valid_i) state_d = go_long_i ? ST_READ : ST_WRITE;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  state_d = ST_MERGE;
      ST_MERGE: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign accept_o  = idle_o && valid_i;
  assign read_o    = (state_q == ST_READ);
  assign capture_o = (state_q == ST_WAIT);
  assign merge_o   = (state_q == ST_MERGE);
  assign write_o   = (state_q == ST_WRITE);

endmodule

// File: rtl/store_merge_unit.sv
module store_merge_unit
  import smu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LANE_W      = 8,
  parameter bit USE_STROBES = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_size_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     req_ready_o,
  output logic [ADDR_W-3:0]        mem_addr_o,
  output logic                     mem_re_o,
  output logic                     mem_we_o,
  output logic [DATA_W/LANE_W-1:0] mem_be_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic [DATA_W-1:0]        mem_rdata_i
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int OFF_W = $clog2(NLANE);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  st_size_e             size_in;
  logic [NLANE-1:0]     map_strobe;
  logic [DATA_W-1:0]    map_lanes;
  logic                 go_long;
  logic idle, accept, st_read, st_cap, st_merge, st_write;

  assign size_in = st_size_e'(req_size_i);

  smu_lane_map #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_map (
    .size_i   (size_in),
    .off_i    (req_addr_i[OFF_W-1:0]),
    .wdata_i  (req_wdata_i),
    .strobe_o (map_strobe),
    .lanes_o  (map_lanes)
  );

  assign go_long = !USE_STROBES && (map_strobe != '1);

  smu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (req_valid_i),
    .go_long_i (go_long),
    .idle_o    (idle),
    .accept_o  (accept),
    .read_o    (st_read),
    .capture_o (st_cap),
    .merge_o   (st_merge),
    .write_o   (st_write)
  );

  // datapath registers with explicit enables
  logic [ADDR_W-3:0]  addr_q;
  st_size_e           size_q;
  logic [NLANE-1:0]   strobe_q;
  logic [DATA_W-1:0]  lanes_q, old_q, wdata_q, wdata_d, merged;
  logic               wdata_en;

  smu_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
    .strobe_i (strobe_q),
    .new_i    (lanes_q),
    .old_i    (old_q),
    .word_o   (merged)
  );

  always_comb begin
    wdata_en = accept || st_merge;
    wdata_d  = accept ? map_lanes : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      size_q   <= SZ_BYTE;
      strobe_q <= '0;
      lanes_q  <= '0;
    end else if (accept) begin
      addr_q   <= req_addr_i[ADDR_W-1:OFF_W];
      size_q   <= size_in;
      strobe_q <= map_strobe;
      lanes_q  <= map_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (st_cap) old_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  assign req_ready_o = idle && rst_n;
  assign mem_addr_o  = addr_q;
  assign mem_re_o    = st_read;
  assign mem_we_o    = st_write;
  assign mem_be_o    = USE_STROBES ? strobe_q : '1;
  assign mem_wdata_o = wdata_q;

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (!mem_we_o && req_ready_o));                    // R9
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);              // R9
  AST_READ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> $stable(mem_addr_o));                           // R5
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re_o && mem_we_o));                                    // R6

  if (USE_STROBES) begin : g_strobe_chk
    AST_STROBE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> mem_we_o);                // R2
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && size_q == SZ_BYTE) |-> ($countones(mem_be_o) == 1)); // R3
  end else begin : g_rmw_chk
    AST_READ_LEADS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> ##2 mem_we_o);                                // R6
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> !mem_we_o);                                   // R6
  end

endmodule

// File: tb/store_merge_unit_bench.sv
module store_merge_unit_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          valid_a, valid_b;
  logic [1:0]    size;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;

  logic          ready_a, re_a, we_a;
  logic [AW-3:0] maddr_a;
  logic [3:0]    be_a;
  logic [31:0]   wd_a;

  logic          ready_b, re_b, we_b;
  logic [AW-3:0] maddr_b;
  logic [3:0]    be_b;
  logic [31:0]   wd_b;
  logic [31:0]   rdata_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  store_merge_unit #(.ADDR_W(AW), .USE_STROBES(1'b1)) u_store_merge_unit (
    .clk(clk), .rst_ni(rst_ni), .req_valid_i(valid_a), .req_size_i(size),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready_a),
    .mem_addr_o(maddr_a), .mem_re_o(re_a), .mem_we_o(we_a), .mem_be_o(be_a),
    .mem_wdata_o(wd_a), .mem_rdata_i(32'h0));

  store_merge_unit #(.ADDR_W(AW), .USE_STROBES(1'b0)) u_store_merge_unit_rmw (
    .clk(clk), .rst_ni(rst_ni), .req_valid_i(valid_b), .req_size_i(size),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready_b),
    .mem_addr_o(maddr_b), .mem_re_o(re_b), .mem_we_o(we_b), .mem_be_o(be_b),
    .mem_wdata_o(wd_b), .mem_rdata_i(rdata_b));

  function automatic logic [31:0] memval(input logic [AW-3:0] a);
    return 32'h8C3A_5E71 ^ ({18'h0, a} * 32'h0103_0507);
  endfunction

  // one-cycle read latency memory model
  always @(posedge clk) rdata_b <= memval(maddr_b);

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'b1000 >> off;
    if (sz == 2'd1) return off[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_lanes(input logic [1:0] sz, input logic [1:0] off,
                                            input logic [31:0] d);
    if (sz == 2'd0) return {24'h0, d[7:0]} << (8 * (3 - off));
    if (sz == 2'd1) return off[1] ? {16'h0, d[15:0]} : {d[15:0], 16'h0};
    return d;
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store_lane(input logic [1:0] sz, input logic [AW-3:0] wa,
                            input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    size = sz; addr = {wa, off}; wdata = d; valid_a = 1'b1;
    chk("R9 ready before", {31'h0, ready_a}, 32'd1);
    @(negedge clk);
    valid_a = 1'b0;
    chk("R2 write pulse", {31'h0, we_a}, 32'd1);
    chk("R2 no read", {31'h0, re_a}, 32'd0);
    chk("R3 R4 R10 byte enables", {28'h0, be_a}, {28'h0, exp_be(sz, off)});
    chk("R3 R4 R10 lane data", wd_a, exp_lanes(sz, off, d));
    chk("R5 word address", {18'h0, maddr_a}, {18'h0, wa});
    chk("R9 busy", {31'h0, ready_a}, 32'd0);
    @(negedge clk);
    chk("R2 write ends", {31'h0, we_a}, 32'd0);
    chk("R9 ready back", {31'h0, ready_a}, 32'd1);
  endtask

  task automatic store_rmw(input logic [1:0] sz, input logic [AW-3:0] wa,
                           input logic [1:0] off, input logic [31:0] d);
    logic [31:0] m;
    @(negedge clk);
    size = sz; addr = {wa, off}; wdata = d; valid_b = 1'b1;
    @(negedge clk);
    valid_b = 1'b0;
    chk("R9 busy", {31'h0, ready_b}, 32'd0);
    if (sz[1]) begin
      chk("R8 direct write", {31'h0, we_b}, 32'd1);
      chk("R8 no read", {31'h0, re_b}, 32'd0);
      chk("R8 full enables", {28'h0, be_b}, 32'hF);
      chk("R8 R10 data", wd_b, d);
      chk("R5 word address", {18'h0, maddr_b}, {18'h0, wa});
    end else begin
      chk("R6 read first", {31'h0, re_b}, 32'd1);
      chk("R6 no write yet", {31'h0, we_b}, 32'd0);
      chk("R5 read address", {18'h0, maddr_b}, {18'h0, wa});
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R6 idle gap", {30'h0, re_b, we_b}, 32'd0);
      end
      @(negedge clk);
      m = mask_of(exp_be(sz, off));
      chk("R6 write at fourth", {31'h0, we_b}, 32'd1);
      chk("R7 full enables", {28'h0, be_b}, 32'hF);
      chk("R7 merged word", wd_b, (memval(wa) & ~m) | (exp_lanes(sz, off, d) & m));
      chk("R5 write address", {18'h0, maddr_b}, {18'h0, wa});
    end
    @(negedge clk);
    chk("R9 write ends", {31'h0, we_b}, 32'd0);
    chk("R9 ready back", {31'h0, ready_b}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-3:0] was [3];
    was[0] = 14'h0000; was[1] = 14'h0015; was[2] = 14'h3FFF;
    valid_a = 1'b0; valid_b = 1'b0; size = 2'd0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {29'h0, ready_a, ready_b, 1'b0}, 32'd0);
    chk("R1 reset strobes", {28'h0, re_a, we_a, re_b, we_b}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after release", {30'h0, ready_a, ready_b}, 32'd3);
    chk("R1 strobes idle", {28'h0, re_a, we_a, re_b, we_b}, 32'd0);
    for (int w = 0; w < 3; w++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++) begin
          logic [31:0] d;
          d = 32'h1234_5678 ^ ((w * 16 + s * 4 + o) * 32'h9E37_79B9);
          store_lane(2'(s), was[w], 2'(o), d);
          store_rmw(2'(s), was[w], 2'(o), d);
        end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule